// File: doc/BRIEF.md
# Resolution-Programmable SAR Conversion Sequencer

This block is the digital sequencer of a successive-approximation converter. A start pulse captures a two-bit resolution selector and an alignment choice, then runs a fixed sampling window followed by one binary trial per result bit. In each trial the block drives a trial code to an external comparator and takes back one decision bit. When the last bit is settled, the block formats the code into a 16-bit word and pulses an end-of-conversion strobe.

All timing is counted in half-cycles of the converter clock: `clk` runs at twice the converter rate, so one `clk` tick is half a converter cycle. Sampling lasts 5 ticks (2.5 converter cycles), each trial bit lasts 2 ticks, and one closing tick completes the approximation phase. A full conversion therefore takes 30, 26, 22 or 18 ticks (15, 13, 11 or 9 converter cycles) for 12, 10, 8 or 6 bits.

The controller has four states. IDLE goes to SAMPLE when `start` is high. SAMPLE counts down its window and goes to CONVERT with the MSB trial loaded. CONVERT alternates between a present half and a decide half; after the decide half of the lowest active bit it goes to FINISH. FINISH formats the result and returns to IDLE unconditionally.

Top module: `sar_sequencer`

## Requirements
- R1: `res_sel` selects the result width when the conversion is accepted: 0 gives 12 bits, 1 gives 10, 2 gives 8, 3 gives 6. `busy` stays high for exactly 6 + 2·N ticks, where N is the selected width.
- R2: `start` is taken only in IDLE. `busy` goes high in the tick after the accepting edge and stays high until the conversion ends.
- R3: Sampling covers the 5 ticks after acceptance. `eosmp` is a single-tick pulse in the tick after the fifth edge that follows acceptance.
- R4: When approximation begins, in the same tick as `eosmp`, `trial_code` holds only its MSB (0x800).
- R5: Each step sets the current bit, then clears it again if `cmp_above` is high at the end of that step. Bits are processed from MSB down to the lowest active bit. The final code is the input level truncated to N bits.
- R6: `eoc` is a single-tick pulse in the tick after edge 6 + 2·N following acceptance. `busy` is low in that tick.
- R7: Code bits below the lowest active bit are zero throughout the approximation and in the final code.
- R8: With `align_left` = 0, `result` holds the N-bit code in bits N-1..0, and all higher bits are zero.
- R9: With `align_left` = 1, `result[15:4]` holds the 12-bit code including its zeroed low bits, and `result[3:0]` is zero.
- R10: A `start` that arrives while `busy` is high has no effect. The running conversion keeps its timing, resolution and alignment.
- R11: After reset, `busy`, `eosmp` and `eoc` are low and `result` and `trial_code` are zero. `result` changes only in an `eoc` tick and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the converter rate (one tick = half cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, taken only when idle |
| res_sel | input | 2 | Resolution selector (0:12, 1:10, 2:8, 3:6 bits) |
| align_left | input | 1 | 1 = left-aligned result, 0 = right-aligned |
| cmp_above | input | 1 | Comparator decision: trial code exceeds the input |
| trial_code | output | 12 | Current trial code to the comparator DAC |
| busy | output | 1 | Conversion in progress |
| eosmp | output | 1 | End-of-sampling strobe |
| eoc | output | 1 | End-of-conversion strobe |
| result | output | 16 | Aligned conversion result |

## Verification
The in-line assertions check the following properties on every cycle: the latency from acceptance to `eoc` for the latched width, that `busy` is low during `eoc`, that settings stay fixed while a conversion runs, that the trial code holds only its MSB during the end-of-sampling tick, that the inactive low code bits stay zero, and that a left-aligned result has a zero low nibble. The following can only be shown by the bench's scenarios, which run a behavioural tick model against an ideal comparator: that the final code equals the truncated input level for each resolution and alignment, that the result holds between conversions, that a mid-conversion request is ignored, and that back-to-back starts restart cleanly.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_CONVERT,
        ST_FINISH
    } sar_state_e;
endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int BITS_MAX     = 12,
    parameter int SAMPLE_TICKS = 5,
    localparam int IDX_W       = $clog2(BITS_MAX),
    localparam int CNT_W       = $clog2(SAMPLE_TICKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       res_sel,
    input  logic             align_left,
    output logic             busy,
    output logic             load,
    output logic             decide,
    output logic             last,
    output logic             done,
    output logic             eosmp,
    output logic             eoc,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] lsb,
    output logic             left
);
    sar_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0] idx_q, idx_d, lsb_q, lsb_d;
    logic             phase_q, phase_d, left_q, left_d;
    logic             eosmp_q, eoc_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            lsb_q   <= '0;
            phase_q <= 1'b0;
            left_q  <= 1'b0;
            eosmp_q <= 1'b0;
            eoc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            lsb_q   <= lsb_d;
            phase_q <= phase_d;
            left_q  <= left_d;
            eosmp_q <= load;
            eoc_q   <= done;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        lsb_d   = lsb_q;
        phase_d = phase_q;
        left_d  = left_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SAMPLE;
                    cnt_d   = CNT_W'(SAMPLE_TICKS - 1);
                    lsb_d   = IDX_W'({res_sel, 1'b0});
                    left_d  = align_left;
                end
            end
            ST_SAMPLE: begin
                if (cnt_q == '0) begin
                    state_d = ST_CONVERT;
                    idx_d   = IDX_W'(BITS_MAX - 1);
                    phase_d = 1'b0;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_CONVERT: begin
                phase_d = ~phase_q;
                if (phase_q) begin
                    if (idx_q == lsb_q) state_d = ST_FINISH;
                    else                idx_d   = idx_q - 1'b1;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        load   = (state_q == ST_SAMPLE) && (cnt_q == '0);
        decide = (state_q == ST_CONVERT) && phase_q;
        last   = (idx_q == lsb_q);
        done   = (state_q == ST_FINISH);
        eosmp  = eosmp_q;
        eoc    = eoc_q;
        idx    = idx_q;
        lsb    = lsb_q;
        left   = left_q;
    end

    assert_cfg_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(lsb_q) && $stable(left_q)));
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int BITS_MAX = 12,
    localparam int IDX_W   = $clog2(BITS_MAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                decide,
    input  logic                last,
    input  logic [IDX_W-1:0]    idx,
    input  logic [IDX_W-1:0]    lsb,
    input  logic                cmp_above,
    output logic [BITS_MAX-1:0] code
);
    logic [BITS_MAX-1:0] code_q, code_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    always_comb begin
        code_d = code_q;
        if (load) begin
            code_d = '0;
            code_d[BITS_MAX-1] = 1'b1;
        end else if (decide) begin
            if (cmp_above) code_d[idx] = 1'b0;
            if (!last)     code_d[idx - 1'b1] = 1'b1;
        end
    end

    assign code = code_q;

    assert_low_bits_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        decide |-> ((code_q & ((BITS_MAX'(1) << lsb) - BITS_MAX'(1))) == '0));
endmodule

// File: rtl/sar_result_fmt.sv
module sar_result_fmt #(
    parameter int BITS_MAX = 12,
    parameter int OUT_W    = 16,
    localparam int IDX_W   = $clog2(BITS_MAX),
    localparam int PAD_W   = OUT_W - BITS_MAX
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done,
    input  logic                left,
    input  logic [IDX_W-1:0]    lsb,
    input  logic [BITS_MAX-1:0] code,
    output logic [OUT_W-1:0]    result
);
    logic [OUT_W-1:0] result_q, fmt;

    always_comb begin
        if (left) fmt = OUT_W'(code) << PAD_W;
        else      fmt = OUT_W'(code >> lsb);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    result_q <= '0;
        else if (done) result_q <= fmt;
    end

    assign result = result_q;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
    parameter int BITS_MAX     = 12,
    parameter int OUT_W        = 16,
    parameter int SAMPLE_TICKS = 5,
    localparam int IDX_W       = $clog2(BITS_MAX),
    localparam int LAT_W       = $clog2(SAMPLE_TICKS + 2 * BITS_MAX + 2) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [1:0]          res_sel,
    input  logic                align_left,
    input  logic                cmp_above,
    output logic [BITS_MAX-1:0] trial_code,
    output logic                busy,
    output logic                eosmp,
    output logic                eoc,
    output logic [OUT_W-1:0]    result
);
    logic             load, decide, last, done, left;
    logic [IDX_W-1:0] idx, lsb;

    sar_seq_fsm #(.BITS_MAX(BITS_MAX), .SAMPLE_TICKS(SAMPLE_TICKS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .res_sel(res_sel),
        .align_left(align_left), .busy(busy), .load(load), .decide(decide),
        .last(last), .done(done), .eosmp(eosmp), .eoc(eoc), .idx(idx),
        .lsb(lsb), .left(left)
    );

    sar_approx_reg #(.BITS_MAX(BITS_MAX)) u_approx (
        .clk(clk), .rst_n(rst_n), .load(load), .decide(decide), .last(last),
        .idx(idx), .lsb(lsb), .cmp_above(cmp_above), .code(trial_code)
    );

    sar_result_fmt #(.BITS_MAX(BITS_MAX), .OUT_W(OUT_W)) u_fmt (
        .clk(clk), .rst_n(rst_n), .done(done), .left(left), .lsb(lsb),
        .code(trial_code), .result(result)
    );

    // latency window counter for the R6 check
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              lat_q <= '0;
        else if (!busy && start) lat_q <= '0;
        else if (busy)           lat_q <= lat_q + 1'b1;
    end

    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> (lat_q == LAT_W'(SAMPLE_TICKS + 1 + 2 * (BITS_MAX - int'(lsb)))));
    assert_eoc_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |-> !busy);
    assert_first_trial_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eosmp |-> (trial_code == (BITS_MAX'(1) << (BITS_MAX - 1))));
    assert_left_nibble_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc && left) |-> (result[OUT_W-BITS_MAX-1:0] == '0));
endmodule

// File: tb/sim_sar_sequencer.sv
module sim_sar_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  res_sel = 2'd0;
    logic        align_left = 1'b0;
    logic        cmp_above;
    logic [11:0] trial_code;
    logic        busy, eosmp, eoc;
    logic [15:0] result;
    int          vin = 0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit running = 0;

    always #5 clk = ~clk;

    // ideal comparator
    assign cmp_above = (int'(trial_code) > vin);

    sar_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .res_sel(res_sel),
        .align_left(align_left), .cmp_above(cmp_above), .trial_code(trial_code),
        .busy(busy), .eosmp(eosmp), .eoc(eoc), .result(result)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // behavioural tick model
    bit m_active = 0, m_eoc = 0, m_eos = 0, m_left = 0;
    int m_t = 0, m_n = 12, m_vin = 0, m_code = 0, m_result = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_active = 0; m_eoc = 0; m_eos = 0; m_t = 0; m_code = 0; m_result = 0;
        end else begin
            m_eoc = 0;
            if (m_active) begin
                m_t++;
                if (m_t == 6 + 2 * m_n) begin
                    int sh;
                    sh = 12 - m_n;
                    m_active = 0;
                    m_eoc = 1;
                    m_code = (m_vin >> sh) << sh;
                    m_result = m_left ? (m_code << 4) : (m_vin >> sh);
                end
            end else if (start) begin
                m_active = 1; m_t = 0;
                m_n = 12 - 2 * int'(res_sel);
                m_left = align_left;
                m_vin = vin;
            end
            m_eos = m_active && (m_t == 5);
        end
    end

    int bcnt = 0;
    always @(negedge clk) begin
        if (running) begin
            check(busy == m_active, "R2", busy, m_active);
            check(eosmp == m_eos, "R3", eosmp, m_eos);
            check(eoc == m_eoc, "R6", eoc, m_eoc);
            if (m_eos) check(trial_code == 12'h800, "R4", trial_code, 12'h800);
            if (m_eoc) begin
                check(int'(trial_code) == m_code, "R5", trial_code, m_code);
                check((int'(trial_code) & ((1 << (12 - m_n)) - 1)) == 0, "R7",
                      trial_code, m_code);
                check(bcnt == 6 + 2 * m_n, "R1", bcnt, 6 + 2 * m_n);
                check(int'(result) == m_result, m_left ? "R9" : "R8", result, m_result);
                bcnt = 0;
            end else begin
                check(int'(result) == m_result, "R11", result, m_result);
            end
            if (busy) bcnt++;
        end
    end

    task automatic run(input int r, input bit l, input int v);
        @(negedge clk);
        res_sel = 2'(r); align_left = l; vin = v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_active) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(busy == 0 && eosmp == 0 && eoc == 0, "R11", {busy, eosmp, eoc}, 0);
        check(result == 16'h0, "R11", result, 0);
        check(trial_code == 12'h0, "R11", trial_code, 0);
        rst_n = 1'b1;
        @(negedge clk);
        running = 1;

        for (int r = 0; r < 4; r++) begin
            for (int l = 0; l < 2; l++) begin
                run(r, l[0], 0);
                run(r, l[0], 4095);
                run(r, l[0], 2048);
                run(r, l[0], 2047);
                run(r, l[0], 1234 + 37 * r);
            end
        end

        // R10: request during a running conversion with other settings
        @(negedge clk);
        res_sel = 2'd0; align_left = 1'b0; vin = 3000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        res_sel = 2'd3; align_left = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10", busy, 1);
        while (m_active) @(negedge clk);
        @(negedge clk);
        check(result == 16'd3000, "R10", result, 3000);

        // back-to-back: start held high across two conversions
        @(negedge clk);
        res_sel = 2'd2; align_left = 1'b0; vin = 777; start = 1'b1;
        repeat (30) @(negedge clk);
        start = 1'b0;
        while (m_active) @(negedge clk);
        repeat (3) @(negedge clk);

        running = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule